// File: doc/BRIEF.md
# ALU Control Decoder with Extension-Unit Result Select

This block is the ALU control and result path of an 8-bit multicycle datapath. It decodes the 2-bit operation class from the main controller together with the 6-bit function field of R-type instructions. From these it produces the three ALU control bits and a fourth select bit. The select bit steers a word-wide 2:1 multiplexer between the ALU output and the output of a unary extension unit, such as a sine evaluator.

The extension unit sits outside this block and connects through a pair of ports. The block sends it the first source operand and takes back its result. The unit works in parallel with the ALU, so an extension instruction completes in the same single write-back cycle as any other R-type operation, and the main state machine does not change. The selected result is captured in the ALU output register on every clock edge.

Top module: `alu_ext_top`

## Requirements
- R1: When aluOp is 00, aluCtl is 010 (add) and extSel is 0, whatever the funct value.
- R2: When aluOp is 01, aluCtl is 110 (subtract) and extSel is 0, whatever the funct value.
- R3: When aluOp[1] is 1, funct selects aluCtl: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), 101010 gives 111 (set-less-than). Every other funct value gives 010.
- R4: extSel equals aluOp[1] AND funct[0] AND funct[2] AND funct[3]. It is therefore 1 for the extension function code 101111 and 0 for the five standard codes of R3.
- R5: result equals extResult when extSel is 1. Otherwise it equals the ALU output.
- R6: extOperand always equals srcA. When extSel is 1, srcB has no effect on result.
- R7: The ALU computes srcA+srcB for 010 and srcA-srcB for 110, both modulo 256. It computes bitwise AND for 000 and bitwise OR for 001. For 111 it outputs 1 when srcA is less than srcB as two's-complement numbers, and 0 otherwise.
- R8: aluZero is 1 exactly when the ALU output, before the extension multiplexer, is zero.
- R9: resultQ is 0 while rstN is low. After each rising clock edge with rstN high, it holds the value that result had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the result register |
| aluOp | input | 2 | Operation class from the main controller |
| funct | input | 6 | R-type function field |
| srcA | input | 8 | First source operand |
| srcB | input | 8 | Second source operand |
| extOperand | output | 8 | Operand sent to the extension unit |
| extResult | input | 8 | Result returned by the extension unit |
| aluCtl | output | 3 | Decoded ALU control bits |
| extSel | output | 1 | Extension result select |
| aluZero | output | 1 | ALU output is zero |
| result | output | 8 | Selected combinational result |
| resultQ | output | 8 | Registered result (ALU output register) |

## Verification
The bench sweeps all 256 combinations of aluOp and funct. It runs each one under four operand pairs: all zeros, a pair that straddles the sign boundary, an equal pair, and a pair with a negative first operand. Between them these separate addition from subtraction and signed from unsigned comparison, and they make the zero flag both rise and stay low. A stub extension unit returns a nibble-swapped, XOR-masked copy of its operand, so a wrong mux leg or a wrong operand feed produces a value that is plainly different. A separate pass holds srcA fixed on the extension code and varies srcB, showing that the second operand is ignored.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;
  localparam int DATA_W  = 8;
  localparam int FUNCT_W = 6;
  localparam int OP_W    = 2;
  localparam int CTL_W   = 3;

  typedef enum logic [CTL_W-1:0] {
    CTL_AND = 3'b000,
    CTL_OR  = 3'b001,
    CTL_ADD = 3'b010,
    CTL_SUB = 3'b110,
    CTL_SLT = 3'b111
  } aluCtl_e;

  typedef struct packed {
    aluCtl_e aluCtl;
    logic    extSel;
  } ctlStrobe_t;
endpackage

// File: rtl/alu_ext_dec.sv
module alu_ext_dec
  import alu_ext_pkg::*;
(
  input  logic [OP_W-1:0]    aluOp,
  input  logic [FUNCT_W-1:0] funct,
  output ctlStrobe_t         strobe
);
  aluCtl_e ctl;
  logic    sel;

  always_comb begin
    ctl = CTL_ADD;
    case (aluOp)
      2'b00:   ctl = CTL_ADD;
      2'b01:   ctl = CTL_SUB;
      default: begin
        case (funct)
          6'b100000: ctl = CTL_ADD;
          6'b100010: ctl = CTL_SUB;
          6'b100100: ctl = CTL_AND;
          6'b100101: ctl = CTL_OR;
          6'b101010: ctl = CTL_SLT;
          default:   ctl = CTL_ADD;
        endcase
      end
    endcase
    sel = aluOp[1] & funct[0] & funct[2] & funct[3];
    strobe.aluCtl = ctl;
    strobe.extSel = sel;
  end

  // R4: the extension code must always select the extension leg
  always_comb begin
    if (aluOp[1] && funct == 6'b101111)
      a_r4_ext_code_sel: assert (sel);
  end
endmodule

// File: rtl/alu_ext_datapath.sv
module alu_ext_datapath
  import alu_ext_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] extResult,
  output logic [DATA_W-1:0] extOperand,
  output logic              aluZero,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] resultQ
);
  logic              bInv;
  logic [DATA_W-1:0] bMod;
  logic [DATA_W-1:0] sum;
  logic              lessThan;
  logic [DATA_W-1:0] aluY;

  assign extOperand = srcA;
  assign bInv       = strobe.aluCtl[CTL_W-1];
  assign bMod       = srcB ^ {DATA_W{bInv}};
  assign sum        = srcA + bMod + DATA_W'(bInv);
  assign lessThan   = $signed(srcA) < $signed(srcB);

  always_comb begin
    case (strobe.aluCtl[1:0])
      2'b00:   aluY = srcA & bMod;
      2'b01:   aluY = srcA | bMod;
      2'b10:   aluY = sum;
      default: aluY = {{(DATA_W-1){1'b0}}, lessThan};
    endcase
  end

  assign aluZero = (aluY == '0);
  assign result  = strobe.extSel ? extResult : aluY;

  always_ff @(posedge clk) begin
    if (!rstN) resultQ <= '0;
    else       resultQ <= result;
  end

  // R9: the output register tracks the selected result
  a_r9_reg_tracks: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> resultQ == $past(result));

  // R8: a zero flag outside the extension leg means the written result is zero
  a_r8_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    (aluZero && !strobe.extSel) |-> result == '0);
endmodule

// File: rtl/alu_ext_top.sv
module alu_ext_top
  import alu_ext_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     aluOp,
  input  logic [FUNCT_W-1:0]  funct,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W-1:0]   srcB,
  output logic [DATA_W-1:0]   extOperand,
  input  logic [DATA_W-1:0]   extResult,
  output logic [CTL_W-1:0]    aluCtl,
  output logic                extSel,
  output logic                aluZero,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W-1:0]   resultQ
);
  ctlStrobe_t strobe;

  alu_ext_dec u_dec (
    .aluOp  (aluOp),
    .funct  (funct),
    .strobe (strobe)
  );

  alu_ext_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcA       (srcA),
    .srcB       (srcB),
    .extResult  (extResult),
    .extOperand (extOperand),
    .aluZero    (aluZero),
    .result     (result),
    .resultQ    (resultQ)
  );

  assign aluCtl = strobe.aluCtl;
  assign extSel = strobe.extSel;

  // R1: address-calculation class adds and never selects the extension
  a_r1_addr_add: assert property (@(posedge clk) disable iff (!rstN)
    aluOp == 2'b00 |-> (aluCtl == 3'b010 && !extSel));

  // R2: branch class subtracts and never selects the extension
  a_r2_branch_sub: assert property (@(posedge clk) disable iff (!rstN)
    aluOp == 2'b01 |-> (aluCtl == 3'b110 && !extSel));

  // R3: standard R-type codes keep the ALU leg on the result bus
  a_r3_std_no_ext: assert property (@(posedge clk) disable iff (!rstN)
    (aluOp[1] && (funct == 6'b100000 || funct == 6'b100010 || funct == 6'b100100 ||
                  funct == 6'b100101 || funct == 6'b101010)) |-> !extSel);

  // R5: when the extension leg is chosen the bus carries its value
  a_r5_ext_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    extSel |-> result == extResult);

  // R6: the extension unit always sees the first operand
  a_r6_operand_feed: assert property (@(posedge clk) disable iff (!rstN)
    extOperand == srcA);
endmodule

// File: tb/alu_ext_top_bench.sv
`timescale 1ns/1ps
module alu_ext_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] aluOp = '0;
  logic [5:0] funct = '0;
  logic [7:0] srcA = '0, srcB = '0;
  logic [7:0] extOperand, extResult;
  logic [2:0] aluCtl;
  logic       extSel, aluZero;
  logic [7:0] result, resultQ;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // stub extension unit: nibble swap then XOR mask
  assign extResult = {extOperand[3:0], extOperand[7:4]} ^ 8'hA5;

  alu_ext_top u_alu_ext_top (
    .clk(clk), .rstN(rstN), .aluOp(aluOp), .funct(funct),
    .srcA(srcA), .srcB(srcB), .extOperand(extOperand), .extResult(extResult),
    .aluCtl(aluCtl), .extSel(extSel), .aluZero(aluZero),
    .result(result), .resultQ(resultQ)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (op=%b funct=%b a=%h b=%h)",
               tag, act, exp, aluOp, funct, srcA, srcB);
    end
  endtask

  function automatic logic [2:0] expCtl(input logic [1:0] op, input logic [5:0] f);
    if (op == 2'b00) return 3'b010;
    if (op == 2'b01) return 3'b110;
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [7:0] expAlu(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b);
    case (c)
      3'b010:  return 8'(a + b);
      3'b110:  return 8'(a - b);
      3'b000:  return a & b;
      3'b001:  return a | b;
      default: return ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
    endcase
  endfunction

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] pa [4];
    logic [7:0] pb [4];
    logic [7:0] held;
    pa[0] = 8'h00; pb[0] = 8'h00;
    pa[1] = 8'h7F; pb[1] = 8'h80;
    pa[2] = 8'h35; pb[2] = 8'h35;
    pa[3] = 8'hC3; pb[3] = 8'h1D;

    // R9: reset state
    srcA = 8'h5C; srcB = 8'h01;
    @(posedge clk); @(posedge clk); #1;
    check(resultQ == 8'h00, "R9 reset", resultQ, 0);
    rstN = 1'b1;

    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int f = 0; f < 64; f++) begin
          logic [2:0] ec;
          logic       es;
          logic [7:0] ea, er, ex;
          aluOp = 2'(o); funct = 6'(f); srcA = pa[p]; srcB = pb[p];
          ec = expCtl(aluOp, funct);
          es = aluOp[1] & funct[0] & funct[2] & funct[3];
          ea = expAlu(ec, srcA, srcB);
          ex = {srcA[3:0], srcA[7:4]} ^ 8'hA5;
          er = es ? ex : ea;
          #1;
          if (o == 0)      check(aluCtl == ec && !extSel, "R1", {aluCtl, extSel}, {ec, 1'b0});
          else if (o == 1) check(aluCtl == ec && !extSel, "R2", {aluCtl, extSel}, {ec, 1'b0});
          else             check(aluCtl == ec, "R3", aluCtl, ec);
          check(extSel == es, "R4", extSel, es);
          check(result == er, es ? "R5 ext leg" : "R5/R7 alu leg", result, er);
          check(extOperand == srcA, "R6 operand", extOperand, srcA);
          check(aluZero == (ea == 8'h00), "R8", aluZero, ea == 8'h00);
          @(posedge clk); #1;
          check(resultQ == er, "R9 register", resultQ, er);
        end
      end
    end

    // R6: srcB ignored on the extension code
    aluOp = 2'b10; funct = 6'b101111; srcA = 8'h96; srcB = 8'h00;
    #1 held = result;
    for (int b = 0; b < 256; b += 17) begin
      srcB = 8'(b);
      #1 check(result == held, "R6 srcB ignored", result, held);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule